// File: doc/BRIEF.md
# Relocatable Memory Map Decoder

This block turns a 16-bit CPU address into one selection among five targets: the 64-byte control register block, internal RAM, EEPROM, ROM, or the external bus. The register block and RAM each sit at the start of a 4 KB page, and an 8-bit mapping register names those pages. The EEPROM is a 2 KB window in the upper half of a page given by a configuration field. ROM occupies a fixed parameterised range.

Configuration comes from a nonvolatile byte presented on `cfg_nv_i`. The block copies this byte into working latches while reset is asserted, and only the latches steer the decode. A changed stored byte therefore has no effect until the next reset. The operating mode is captured at reset in the same way. Reading the configuration location inside the register block returns the latches. Reading the mapping location returns the mapping register.

In normal modes the mapping register can be written once, and only within a short window after reset. In special modes it can be rewritten at any time. The decode is combinational from the address. Register writes take effect at the clock edge.

Top module: `mem_map_decoder`

## Requirements
- R1: While `rst_ni` is low, the mapping register is set to 0x01, which places RAM at page 0 and the register block at page 1 ($1000). `mode_i` and `cfg_nv_i` are captured into latches at the same time.
- R2: The RAM output is asserted for addresses from {map[7:4],12'h000} up to that base plus RAM_BYTES-1 (default 512 bytes).
- R3: The register output is asserted for the 64 bytes starting at {map[3:0],12'h000}.
- R4: The EEPROM output covers {cfg[7:4],12'h800} through {cfg[7:4],12'hFFF}, and only while latch bit cfg[0] is 1. Otherwise that range falls through to lower-priority targets or to external.
- R5: The ROM output covers ROM_BASE through ROM_BASE+ROM_BYTES-1 (default $D000–$FFFF). It requires latch bit cfg[1]=1, except in single-chip mode (mode 2'b00), where ROM is always present.
- R6: Where regions overlap, the register block wins over RAM, RAM wins over EEPROM, and EEPROM wins over ROM.
- R7: An address that no enabled region claims asserts `ext_o`. Exactly one of the five select outputs is high at all times outside reset.
- R8: The configuration latches and the mode hold their reset-time values. A change on `cfg_nv_i` or `mode_i` after reset changes neither the readback nor the decode until the next reset.
- R9: A read at register-block offset 6'h3F returns the configuration latches. Offset 6'h3D returns the mapping register. All other addresses return 0.
- R10: In normal modes (mode_i[1]=0), a write of `wdata_i` to offset 6'h3D is accepted only if no earlier write has been accepted since reset and fewer than WIN_CYCLES (64) clock edges have passed since reset was released. Any other write leaves the mapping unchanged.
- R11: In special modes (mode_i[1]=1), every write to offset 6'h3D updates the mapping register, at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; latches load while low |
| mode_i | input | 2 | Mode pins: 00 single-chip, 01 expanded, 10 bootstrap, 11 test |
| cfg_nv_i | input | 8 | Stored configuration byte |
| addr_i | input | 16 | CPU address |
| wr_i | input | 1 | Write strobe, sampled at the clock edge |
| wdata_i | input | 8 | Write data |
| sel_reg_o | output | 1 | Register block selected |
| sel_ram_o | output | 1 | Internal RAM selected |
| sel_eep_o | output | 1 | EEPROM selected |
| sel_rom_o | output | 1 | ROM selected |
| ext_o | output | 1 | Access goes to the external bus |
| rdata_o | output | 8 | Readback of the mapping register or the configuration latches |

## Verification
The select outputs and `rdata_o` are combinational from `addr_i` and the held state. The bench therefore drives an address on the falling edge and samples 1 ns later, in the same low phase, with no clock edge in between. A mapping write takes effect at the next rising edge, so the bench raises `wr_i` on a falling edge, lets one rising edge pass, and checks at the following falling edge. For the late-write case, the bench counts 70 rising edges after reset before writing. Latch checks change `cfg_nv_i` after reset and read back before and after a new reset pulse.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } mode_e;

  typedef struct packed {
    logic [3:0] eep_pg;
    logic [1:0] spare;
    logic       rom_en;
    logic       eep_en;
  } cfg_t;

  localparam int unsigned PAGE_BITS  = 4;
  localparam int unsigned REG_BYTES  = 64;
  localparam int unsigned EEP_BYTES  = 2048;
  localparam int unsigned N_REGIONS  = 4;
endpackage

// File: rtl/mm_window.sv
module mm_window #(
  parameter int unsigned AW   = 16,
  parameter int unsigned SIZE = 512
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  localparam logic [AW:0] SZ = (AW+1)'(SIZE);
  logic [AW:0] diff;
  // borrow lands in the top bit, so any address below base exceeds SZ
  assign diff  = {1'b0, addr_i} - {1'b0, base_i};
  assign hit_o = diff < SZ;
endmodule

// File: rtl/mm_arbiter.sv
module mm_arbiter #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,   // bit 0 has highest priority
  output logic [N-1:0] gnt_o,
  output logic         none_o
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pri
    assign gnt_o[i]   = req_i[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req_i[i];
  end
  assign none_o = ~taken[N];
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 64,
  parameter logic [7:0]  MAP_RESET  = 8'h01
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic [7:0] cfg_nv_i,
  input  logic       map_wr_i,
  input  logic [7:0] wdata_i,
  output mode_e      mode_o,
  output cfg_t       cfg_o,
  output logic [7:0] map_o,
  output logic       locked_o
);
  localparam int unsigned CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(WIN_CYCLES);

  mode_e       mode_q;
  cfg_t        cfg_q;
  logic [7:0]  map_q;
  logic [CW-1:0] cnt_q;
  logic        used_q;
  logic        special;
  logic        wr_ok;

  // latches follow the stored byte only while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= mode_e'(mode_i);
      cfg_q  <= cfg_t'(cfg_nv_i);
    end
  end

  assign special = mode_q[1];
  assign wr_ok   = map_wr_i & (special | (~used_q & (cnt_q != CNT_MAX)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      used_q <= 1'b0;
      map_q  <= MAP_RESET;
    end else begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (wr_ok) begin
        map_q  <= wdata_i;
        used_q <= 1'b1;
      end
    end
  end

  assign mode_o   = mode_q;
  assign cfg_o    = cfg_q;
  assign map_o    = map_q;
  assign locked_o = ~special & (used_q | (cnt_q == CNT_MAX));
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mm_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned RAM_BYTES  = 512,
  parameter logic [15:0] ROM_BASE   = 16'hD000,
  parameter int unsigned ROM_BYTES  = 12288,
  parameter int unsigned WIN_CYCLES = 64,
  parameter logic [5:0]  MAP_OFS    = 6'h3D,
  parameter logic [5:0]  CFG_OFS    = 6'h3F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [7:0]    cfg_nv_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  output logic          sel_reg_o,
  output logic          sel_ram_o,
  output logic          sel_eep_o,
  output logic          sel_rom_o,
  output logic          ext_o,
  output logic [7:0]    rdata_o
);
  localparam int unsigned LOW = AW - PAGE_BITS;

  mode_e       mode_w;
  cfg_t        cfg_w;
  logic [7:0]  map_w;
  logic        locked_w;
  logic        map_wr;
  logic [5:0]  ofs;

  logic [AW-1:0] base [N_REGIONS];
  logic [N_REGIONS-1:0] hit, en, gnt;
  logic none;

  assign ofs    = addr_i[5:0];
  assign map_wr = wr_i & hit[0] & (ofs == MAP_OFS);

  mm_ctrl #(.WIN_CYCLES(WIN_CYCLES), .MAP_RESET(8'h01)) u_ctrl (
    .clk_i, .rst_ni, .mode_i, .cfg_nv_i,
    .map_wr_i (map_wr),
    .wdata_i,
    .mode_o   (mode_w),
    .cfg_o    (cfg_w),
    .map_o    (map_w),
    .locked_o (locked_w)
  );

  // index order is the priority order
  assign base[0] = {map_w[3:0], {LOW{1'b0}}};
  assign base[1] = {map_w[7:4], {LOW{1'b0}}};
  assign base[2] = {cfg_w.eep_pg, 1'b1, {(LOW-1){1'b0}}};
  assign base[3] = AW'(ROM_BASE);

  localparam int unsigned SIZES [N_REGIONS] = '{REG_BYTES, RAM_BYTES, EEP_BYTES, ROM_BYTES};

  for (genvar i = 0; i < N_REGIONS; i++) begin : g_win
    mm_window #(.AW(AW), .SIZE(SIZES[i])) u_win (
      .base_i (base[i]),
      .addr_i (addr_i),
      .hit_o  (hit[i])
    );
  end

  assign en = {cfg_w.rom_en | (mode_w == MODE_SINGLE), cfg_w.eep_en, 2'b11};

  mm_arbiter #(.N(N_REGIONS)) u_arb (
    .req_i  (hit & en),
    .gnt_o  (gnt),
    .none_o (none)
  );

  assign sel_reg_o = gnt[0];
  assign sel_ram_o = gnt[1];
  assign sel_eep_o = gnt[2];
  assign sel_rom_o = gnt[3];
  assign ext_o     = none;

  always_comb begin
    rdata_o = 8'h00;
    if (gnt[0] && ofs == CFG_OFS) rdata_o = cfg_w;
    else if (gnt[0] && ofs == MAP_OFS) rdata_o = map_w;
  end
endmodule

// File: rtl/mem_map_decoder_chk.sv
module mem_map_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic        sel_reg_o,
  input logic        sel_ram_o,
  input logic        sel_eep_o,
  input logic        sel_rom_o,
  input logic        ext_o,
  input logic [1:0]  mode_w,
  input logic [7:0]  cfg_w,
  input logic [7:0]  map_w,
  input logic        locked_w
);
  // R7
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({sel_reg_o, sel_ram_o, sel_eep_o, sel_rom_o, ext_o}) == 1);
  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(cfg_w) && $stable(mode_w));
  // R10
  map_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_w |=> $stable(map_w));
  // R3
  reg_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_reg_o |-> (addr_i[15:12] == map_w[3:0]) && (addr_i[11:6] == 6'd0));
  // R2
  ram_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ram_o |-> addr_i[15:12] == map_w[7:4]);
  // R4
  eep_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_eep_o |-> cfg_w[0] && addr_i[15:11] == {cfg_w[7:4], 1'b1});
  // R5
  rom_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rom_o |-> cfg_w[1] || mode_w == 2'b00);
endmodule

bind mem_map_decoder mem_map_decoder_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .sel_reg_o (sel_reg_o),
  .sel_ram_o (sel_ram_o),
  .sel_eep_o (sel_eep_o),
  .sel_rom_o (sel_rom_o),
  .ext_o     (ext_o),
  .mode_w    (mode_w),
  .cfg_w     (cfg_w),
  .map_w     (map_w),
  .locked_w  (locked_w)
);

// File: tb/mem_map_decoder_tb.sv
module mem_map_decoder_tb;
  localparam int C_EXT = 0, C_REG = 1, C_RAM = 2, C_EEP = 3, C_ROM = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b01;
  logic [7:0]  cfg_nv_i = 8'h00;
  logic [15:0] addr_i = 16'h0;
  logic        wr_i = 1'b0;
  logic [7:0]  wdata_i = 8'h0;
  logic        sel_reg_o, sel_ram_o, sel_eep_o, sel_rom_o, ext_o;
  logic [7:0]  rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  mem_map_decoder u_dut (
    .clk_i, .rst_ni, .mode_i, .cfg_nv_i, .addr_i, .wr_i, .wdata_i,
    .sel_reg_o, .sel_ram_o, .sel_eep_o, .sel_rom_o, .ext_o, .rdata_o
  );

  function automatic int code_now();
    logic [4:0] v;
    v = {sel_rom_o, sel_eep_o, sel_ram_o, sel_reg_o, ext_o};
    case (v)
      5'b00001: return C_EXT;
      5'b00010: return C_REG;
      5'b00100: return C_RAM;
      5'b01000: return C_EEP;
      5'b10000: return C_ROM;
      default:  return -1;
    endcase
  endfunction

  task automatic chk_sel(input logic [15:0] a, input int exp, input string req);
    @(negedge clk_i);
    addr_i = a;
    #1;
    checks++;
    if (code_now() != exp) begin
      errors++;
      $display("FAIL %s addr=%h target actual=%0d expected=%0d", req, a, code_now(), exp);
    end
  endtask

  task automatic chk_rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk_i);
    addr_i = a;
    #1;
    checks++;
    if (rdata_o !== exp) begin
      errors++;
      $display("FAIL %s addr=%h rdata actual=%h expected=%h", req, a, rdata_o, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [7:0] c);
    @(negedge clk_i);
    rst_ni = 1'b0; mode_i = m; cfg_nv_i = c; wr_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic t_reset_map();
    do_reset(2'b01, 8'hF3);
    chk_rd (16'h103D, 8'h01, "R1");
    chk_sel(16'h0000, C_RAM, "R1");
    chk_sel(16'h01FF, C_RAM, "R2");
    chk_sel(16'h0200, C_EXT, "R7");
    chk_sel(16'h1000, C_REG, "R3");
    chk_sel(16'h103F, C_REG, "R3");
    chk_sel(16'h1040, C_EXT, "R3");
    chk_rd (16'h103F, 8'hF3, "R9");
    chk_rd (16'h1010, 8'h00, "R9");
    chk_sel(16'hF800, C_EEP, "R6");
    chk_sel(16'hF7FF, C_ROM, "R5");
    chk_sel(16'hCFFF, C_EXT, "R7");
  endtask

  task automatic t_enables();
    do_reset(2'b01, 8'h50);
    chk_sel(16'h5800, C_EXT, "R4");
    chk_sel(16'hD000, C_EXT, "R5");
    do_reset(2'b01, 8'h51);
    chk_sel(16'h5800, C_EEP, "R4");
    chk_sel(16'h57FF, C_EXT, "R4");
    do_reset(2'b00, 8'h50);
    chk_sel(16'hD000, C_ROM, "R5");
    chk_sel(16'h5FFF, C_EXT, "R4");
  endtask

  task automatic t_latch();
    do_reset(2'b00, 8'h50);
    @(negedge clk_i);
    cfg_nv_i = 8'hF3; mode_i = 2'b11;
    chk_rd (16'h103F, 8'h50, "R8");
    chk_sel(16'hF800, C_ROM, "R8");
    // mode change after reset must not unlock the mapping
    repeat (70) @(negedge clk_i);
    do_write(16'h103D, 8'h00);
    chk_rd (16'h103D, 8'h01, "R8");
    do_reset(2'b01, 8'hF3);
    chk_rd (16'h103F, 8'hF3, "R8");
    chk_sel(16'hF800, C_EEP, "R8");
  endtask

  task automatic t_map_once();
    do_reset(2'b01, 8'h03);
    do_write(16'h103D, 8'h23);
    chk_sel(16'h3000, C_REG, "R10");
    chk_sel(16'h1000, C_EXT, "R10");
    chk_sel(16'h2000, C_RAM, "R10");
    chk_rd (16'h303D, 8'h23, "R10");
    do_write(16'h303D, 8'h45);
    chk_rd (16'h303D, 8'h23, "R10");
    do_reset(2'b10, 8'h03);
    repeat (70) @(negedge clk_i);
    do_write(16'h103D, 8'h00);
    do_reset(2'b00, 8'h03);
    repeat (70) @(negedge clk_i);
    do_write(16'h103D, 8'h00);
    chk_rd (16'h103D, 8'h01, "R10");
    chk_sel(16'h0000, C_RAM, "R10");
  endtask

  task automatic t_special();
    do_reset(2'b11, 8'h03);
    repeat (70) @(negedge clk_i);
    do_write(16'h103D, 8'h00);
    chk_sel(16'h0000, C_REG, "R11");
    chk_sel(16'h0040, C_RAM, "R6");
    chk_sel(16'h0800, C_EEP, "R6");
    do_write(16'h003D, 8'h77);
    chk_rd (16'h703D, 8'h77, "R11");
    chk_sel(16'h7100, C_RAM, "R11");
    do_write(16'h703D, 8'hDD);
    chk_sel(16'hD000, C_REG, "R6");
    chk_sel(16'hD040, C_RAM, "R6");
    chk_sel(16'hD200, C_ROM, "R6");
  endtask

  initial begin
    t_reset_map();
    t_enables();
    t_latch();
    t_map_once();
    t_special();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule